// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. Software programs it through one control write. That write carries an enable bit, a start bit that doubles as the busy flag, a 3-bit code that selects the acquisition time, a 2-bit exponent for the conversion clock divider, and a bit that picks the result layout. Once started, the block can first hold the sampling switch closed for a programmable number of conversion clock periods. It then opens the switch and runs an 11-period conversion frame. During the frame it drives trial codes to an external DAC and reads back a comparator.

When the frame ends, the block does four things on one clock: it writes the result into a high/low register pair, drops the start bit, raises a sticky completion flag and closes the sampling switch again. A two-period discharge phase follows before the block goes idle. The capacitor array, the DAC and the comparator sit outside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A control write (`ctrl_we_i`) with `go_wd_i`=1 starts a sequence only if `en_o` is already 1, `en_wd_i` is 1 and the block is idle. A write that sets the enable bit from 0 sets enable only, and `go_o` stays 0.
- R2: The acquisition code maps to this many conversion periods: 000 to 0, 001 to 2, 010 to 4, 011 to 6, 100 to 8, 101 to 12, 110 to 16, 111 to 20. `hold_conn_o` first reads 0 in the clock cycle that begins 1 + A·T clocks after the starting write's edge.
- R3: A conversion period lasts T = 2^N system clocks, where N is the 2-bit `div_wd_i` value latched by the control write.
- R4: The frame lasts 11 periods with `hold_conn_o`=0 throughout. Period 0 shows `dac_code_o`=0. Periods 1 to 10 each try one result bit, from bit 9 down to bit 0. The DAC code during a period is the bits kept so far with the trial bit set, so period 1 shows 512. A bit is kept when `cmp_i`=1, which means the input is at or above the trial code.
- R5: One clock after the frame ends, the result registers load, `go_o` falls, `flag_o` rises and `hold_conn_o` returns to 1, all on the same edge. `go_o` therefore falls (A+11)·T+2 clocks after the starting write's edge. The result registers change at no other time.
- R6: A discharge phase of 2·T clocks, shown on `discharge_o`, follows each completion. Start writes during discharge are ignored.
- R7: With `rjust_wd_i`=1, `res_hi_o`[1:0] holds result bits 9:8, `res_lo_o` holds bits 7:0 and the unused bits are 0. With `rjust_wd_i`=0, `res_hi_o` holds bits 9:2, `res_lo_o`[7:6] holds bits 1:0 and the unused bits are 0.
- R8: `flag_o` stays 1 until a `flag_clr_i` pulse clears it.
- R9: A control write with `en_wd_i`=0 aborts any sequence on the next edge. `go_o` and `en_o` drop, `hold_conn_o` returns to 1, and the results and `flag_o` are left unchanged.
- R10: After reset, `en_o`, `go_o`, `flag_o`, `discharge_o`, `dac_code_o` and both result registers are 0, and `hold_conn_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| en_wd_i | input | 1 | Enable bit value written |
| go_wd_i | input | 1 | Start bit value written |
| acq_wd_i | input | 3 | Acquisition time code written |
| div_wd_i | input | 2 | Conversion clock divider exponent written |
| rjust_wd_i | input | 1 | Result layout written: 1 right-justified, 0 left-justified |
| flag_clr_i | input | 1 | Clears the completion flag |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above `dac_code_o` |
| en_o | output | 1 | Enable bit |
| go_o | output | 1 | Start/busy bit |
| flag_o | output | 1 | Sticky completion flag |
| hold_conn_o | output | 1 | 1 when the hold capacitor is connected to the input |
| discharge_o | output | 1 | Discharge phase active |
| dac_code_o | output | 10 | Trial code for the DAC |
| res_hi_o | output | 8 | Result register, high byte |
| res_lo_o | output | 8 | Result register, low byte |

## Verification
A wrong phase counter or a divider tick off by one shifts the cycles in which `hold_conn_o` falls, `go_o` falls and `discharge_o` ends. Each shift is a multiple of T, and the ports show it within the one sequence where it occurs. A bad successive-approximation register or trial-bit index shows up in the `dac_code_o` value one period after the switch opens. It also shows up in the result pair as soon as that conversion completes. Faulty enable, abort or flag state is visible at `go_o` and `flag_o` on the clock after the write that triggers it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ACQ, ST_CONV, ST_FIN, ST_DISCH
  } seq_st_e;

  localparam int ACQ_MAX = 20;
  localparam int ACQ_W   = $clog2(ACQ_MAX + 1);

  function automatic logic [ACQ_W-1:0] acq_periods(input logic [2:0] sel);
    case (sel)
      3'd0:    return ACQ_W'(0);
      3'd1:    return ACQ_W'(2);
      3'd2:    return ACQ_W'(4);
      3'd3:    return ACQ_W'(6);
      3'd4:    return ACQ_W'(8);
      3'd5:    return ACQ_W'(12);
      3'd6:    return ACQ_W'(16);
      default: return ACQ_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/sar_presc.sv
module sar_presc #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(div_i));
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             trial_en_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] val_o
);
  logic [RES_W-1:0] sar_q, trial;

  for (genvar g = 0; g < RES_W; g++) begin : g_trial
    assign trial[g] = trial_en_i && (bit_idx_i == IDX_W'(g));
  end

  assign code_o = sar_q | trial;
  assign val_o  = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sar_q <= '0;
    else if (clr_i)  sar_q <= '0;
    else if (step_i) sar_q <= cmp_i ? (sar_q | trial) : sar_q;
  end
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             rjust_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int PAD = 2 * REG_W - RES_W;

  logic [2*REG_W-1:0] pair;

  assign pair = rjust_i ? {{PAD{1'b0}}, res_i} : {res_i, {PAD{1'b0}}};
  assign hi_o = pair[2*REG_W-1:REG_W];
  assign lo_o = pair[REG_W-1:0];
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int REG_W   = 8,
  parameter int DIV_W   = 2,
  parameter int DISCH_P = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             en_wd_i,
  input  logic             go_wd_i,
  input  logic [2:0]       acq_wd_i,
  input  logic [DIV_W-1:0] div_wd_i,
  input  logic             rjust_wd_i,
  input  logic             flag_clr_i,
  input  logic             cmp_i,
  output logic             en_o,
  output logic             go_o,
  output logic             flag_o,
  output logic             hold_conn_o,
  output logic             discharge_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  localparam int FRAME_P = RES_W + 1;
  localparam int PMAX_A  = (ACQ_MAX > FRAME_P) ? ACQ_MAX : FRAME_P;
  localparam int PMAX    = (PMAX_A > DISCH_P) ? PMAX_A : DISCH_P;
  localparam int PER_W   = $clog2(PMAX + 1);
  localparam int IDX_W   = $clog2(RES_W);

  seq_st_e          st_q, st_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             en_q, go_q, flag_q, rjust_q;
  logic [2:0]       acq_q;
  logic [DIV_W-1:0] div_q;
  logic [REG_W-1:0] hi_q, lo_q, hi_fmt, lo_fmt;
  logic [RES_W-1:0] sar_val;
  logic [PER_W-1:0] acq_len;
  logic             tick, go_start, abort, fin_load, presc_run;
  logic             trial_en, step;
  logic [IDX_W-1:0] bit_idx;

  assign abort    = ctrl_we_i && !en_wd_i;
  assign go_start = ctrl_we_i && en_q && en_wd_i && go_wd_i && !go_q && (st_q == ST_IDLE);
  assign fin_load = (st_q == ST_FIN) && !abort;
  assign acq_len  = PER_W'(acq_periods(acq_q));
  assign presc_run = (st_q == ST_ACQ) || (st_q == ST_CONV) || (st_q == ST_DISCH);

  sar_presc #(.DIV_W(DIV_W)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (presc_run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  // period k in 1..RES_W of the frame tries bit RES_W-k
  assign trial_en = (st_q == ST_CONV) && (per_q != '0);
  assign step     = trial_en && tick;
  assign bit_idx  = trial_en ? IDX_W'(RES_W - int'(per_q)) : '0;

  sar_approx #(.RES_W(RES_W)) approx_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (st_q == ST_START),
    .trial_en_i (trial_en),
    .step_i     (step),
    .bit_idx_i  (bit_idx),
    .cmp_i      (cmp_i),
    .code_o     (dac_code_o),
    .val_o      (sar_val)
  );

  sar_result_fmt #(.RES_W(RES_W), .REG_W(REG_W)) fmt_i (
    .res_i   (sar_val),
    .rjust_i (rjust_q),
    .hi_o    (hi_fmt),
    .lo_o    (lo_fmt)
  );

  always_comb begin
    st_d  = st_q;
    per_d = per_q;
    unique case (st_q)
      ST_IDLE: if (go_start) begin st_d = ST_START; per_d = '0; end
      ST_START: begin
        st_d  = (acq_len == '0) ? ST_CONV : ST_ACQ;
        per_d = '0;
      end
      ST_ACQ: if (tick) begin
        if (per_q == acq_len - 1'b1) begin st_d = ST_CONV; per_d = '0; end
        else per_d = per_q + 1'b1;
      end
      ST_CONV: if (tick) begin
        if (per_q == PER_W'(FRAME_P - 1)) begin st_d = ST_FIN; per_d = '0; end
        else per_d = per_q + 1'b1;
      end
      ST_FIN: begin st_d = ST_DISCH; per_d = '0; end
      ST_DISCH: if (tick) begin
        if (per_q == PER_W'(DISCH_P - 1)) begin st_d = ST_IDLE; per_d = '0; end
        else per_d = per_q + 1'b1;
      end
      default: begin st_d = ST_IDLE; per_d = '0; end
    endcase
    if (abort) begin
      st_d  = ST_IDLE;
      per_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      per_q   <= '0;
      en_q    <= 1'b0;
      go_q    <= 1'b0;
      flag_q  <= 1'b0;
      rjust_q <= 1'b0;
      acq_q   <= '0;
      div_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      st_q  <= st_d;
      per_q <= per_d;
      if (ctrl_we_i) begin
        en_q    <= en_wd_i;
        acq_q   <= acq_wd_i;
        div_q   <= div_wd_i;
        rjust_q <= rjust_wd_i;
      end
      if (abort || fin_load) go_q <= 1'b0;
      else if (go_start)     go_q <= 1'b1;
      if (fin_load)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (fin_load) begin
        hi_q <= hi_fmt;
        lo_q <= lo_fmt;
      end
    end
  end

  assign en_o        = en_q;
  assign go_o        = go_q;
  assign flag_o      = flag_q;
  assign hold_conn_o = !((st_q == ST_CONV) || (st_q == ST_FIN));
  assign discharge_o = (st_q == ST_DISCH);
  assign res_hi_o    = hi_q;
  assign res_lo_o    = lo_q;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int REG_W = 8,
  parameter int DIV_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic             en_wd_i,
  input logic             go_wd_i,
  input logic             flag_clr_i,
  input logic             en_o,
  input logic             go_o,
  input logic             flag_o,
  input logic             hold_conn_o,
  input logic             discharge_o,
  input logic [REG_W-1:0] res_hi_o,
  input logic [REG_W-1:0] res_lo_o
);
  assert_en_go_same_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !en_o && go_wd_i |=> !go_o);

  assert_open_only_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_conn_o |-> go_o);

  assert_flag_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $fell(go_o) && hold_conn_o);

  assert_done_enters_disch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_o) && en_o |-> flag_o && discharge_o);

  assert_result_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({res_hi_o, res_lo_o}) |-> $fell(go_o) && en_o);

  assert_disch_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discharge_o |-> hold_conn_o && !go_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !en_wd_i |=> !go_o && !en_o && hold_conn_o && $stable({res_hi_o, res_lo_o}));

  assert_go_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !go_o);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_W(RES_W), .REG_W(REG_W), .DIV_W(DIV_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .en_wd_i     (en_wd_i),
  .go_wd_i     (go_wd_i),
  .flag_clr_i  (flag_clr_i),
  .en_o        (en_o),
  .go_o        (go_o),
  .flag_o      (flag_o),
  .hold_conn_o (hold_conn_o),
  .discharge_o (discharge_o),
  .res_hi_o    (res_hi_o),
  .res_lo_o    (res_lo_o)
);

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0, en_wd = 1'b0, go_wd = 1'b0, rjust_wd = 1'b0, flag_clr = 1'b0;
  logic [2:0] acq_wd = '0;
  logic [1:0] div_wd = '0;
  logic       cmp;
  logic       en, go, flag, hold, disch;
  logic [9:0] dac;
  logic [7:0] res_hi, res_lo;
  int         vin = 0;
  int         n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign cmp = (vin >= int'(dac));

  sar_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .en_wd_i(en_wd), .go_wd_i(go_wd),
    .acq_wd_i(acq_wd), .div_wd_i(div_wd), .rjust_wd_i(rjust_wd), .flag_clr_i(flag_clr),
    .cmp_i(cmp), .en_o(en), .go_o(go), .flag_o(flag), .hold_conn_o(hold),
    .discharge_o(disch), .dac_code_o(dac), .res_hi_o(res_hi), .res_lo_o(res_lo)
  );

  function automatic int acq_len(input int sel);
    int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[sel];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic e, input logic g, input int a, input int d, input logic rj);
    @(negedge clk);
    ctrl_we = 1'b1; en_wd = e; go_wd = g; acq_wd = 3'(a); div_wd = 2'(d); rjust_wd = rj;
    @(negedge clk);
    ctrl_we = 1'b0; go_wd = 1'b0;
  endtask

  task automatic run_conv(input int a, input int d, input logic rj, input int v);
    int t, n, nh, m, ehi, elo;
    t = 1 << d;
    vin = v;
    wr(1'b1, 1'b1, a, d, rj);
    chk("R1 go set", int'(go), 1);
    n = 0; nh = -1;
    while (go && n < 1000) begin
      @(negedge clk);
      n++;
      if (nh < 0 && !hold) begin
        nh = n;
        chk("R4 dac period0", int'(dac), 0);
      end
      if (nh >= 0 && n == nh + t) chk("R4 msb trial", int'(dac), 512);
    end
    chk("R2 hold open cycle", nh, 1 + acq_len(a) * t);
    chk("R5 go fall cycle", n, (acq_len(a) + 11) * t + 2);
    chk("R5 flag set", int'(flag), 1);
    chk("R5 hold back", int'(hold), 1);
    ehi = rj ? (v >> 8) : (v >> 2);
    elo = rj ? (v & 255) : ((v & 3) << 6);
    chk("R7 res_hi", int'(res_hi), ehi);
    chk("R7 res_lo", int'(res_lo), elo);
    m = 0;
    while (disch && m < 100) begin
      @(negedge clk);
      m++;
    end
    chk("R6 discharge len", m, 2 * t);
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", int'(flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R8 flag cleared", int'(flag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ph, pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 en", int'(en), 0);
    chk("R10 go", int'(go), 0);
    chk("R10 flag", int'(flag), 0);
    chk("R10 hold", int'(hold), 1);
    chk("R10 disch", int'(disch), 0);
    chk("R10 dac", int'(dac), 0);
    chk("R10 res", int'({res_hi, res_lo}), 0);

    // R1: start ignored while disabled and in the enabling write
    wr(1'b0, 1'b1, 0, 0, 1'b1);
    chk("R1 disabled go", int'(go), 0);
    wr(1'b1, 1'b1, 0, 0, 1'b1);
    chk("R1 en set", int'(en), 1);
    chk("R1 same write go", int'(go), 0);
    repeat (20) @(negedge clk);
    chk("R1 no start", int'(go) + int'(!hold) + int'(flag), 0);

    // R2 R3 R4 R5 R7 sweep over divider and acquisition codes
    for (int d = 0; d < 3; d++)
      for (int a = 0; a < 8; a++)
        run_conv(a, d, logic'((a ^ d) & 1), (a * 173 + d * 311 + 37) % 1024);
    run_conv(0, 0, 1'b1, 0);
    run_conv(0, 0, 1'b0, 1023);
    run_conv(3, 3, 1'b1, 512);

    // R6: start write during discharge is ignored
    vin = 300;
    wr(1'b1, 1'b1, 0, 2, 1'b1);
    while (go) @(negedge clk);
    wr(1'b1, 1'b1, 0, 2, 1'b1);
    chk("R6 go in discharge", int'(go), 0);
    while (disch) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R6 no restart", int'(go) + int'(!hold), 0);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

    // R9: abort mid-conversion
    ph = int'(res_hi); pl = int'(res_lo);
    vin = 777;
    wr(1'b1, 1'b1, 7, 1, 1'b1);
    repeat (50) @(negedge clk);
    chk("R9 busy before abort", int'(go), 1);
    wr(1'b0, 1'b0, 7, 1, 1'b1);
    chk("R9 go", int'(go), 0);
    chk("R9 en", int'(en), 0);
    chk("R9 hold", int'(hold), 1);
    repeat (100) @(negedge clk);
    chk("R9 flag", int'(flag), 0);
    chk("R9 res_hi", int'(res_hi), ph);
    chk("R9 res_lo", int'(res_lo), pl);
    wr(1'b1, 1'b0, 0, 0, 1'b1);
    run_conv(2, 1, 1'b1, 777);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule